// File: doc/BRIEF.md
# Condition Field Register File

This block keeps eight 4-bit condition fields in flops. Every field can be reached on its own through eight independent read ports and eight independent write ports. The whole set can also be read or loaded as one packed 32-bit word, so a unit that needs all the flags at once gets them in a single cycle.

Reads are combinational from the stored state and show the values held before the current cycle's writes. Writes take effect at the next rising clock edge. When several sources aim at the same field in one cycle, a fixed priority picks the winner. A field write port beats the whole-word write, and among the field ports the higher port number wins. A synchronous reset clears every field.

Top module: `cond_field_file`

## Requirements
- R1: The file holds eight fields, numbered 0 to 7, each 4 bits wide. In the packed word, field f sits at bits [31-4f : 28-4f], so field 0 is bits 31:28 and field 7 is bits 3:0.
- R2: Read port p drives `rd_data[p]` with the field selected by the 3-bit index `rd_idx[p]`. This is combinational and does not depend on the other ports.
- R3: `word_rdata` always shows all eight stored fields packed as in R1.
- R4: When `word_we` is high, every field not targeted by an enabled field port loads its slice of `word_wdata` at the next rising edge.
- R5: When `wr_en[p]` is high, field `wr_idx[p]` takes `wr_data[p]` at the next rising edge. Fields that nothing targets keep their value.
- R6: When two or more enabled field ports name the same field, the port with the highest number decides that field's new value.
- R7: For the field it targets, an enabled field port takes priority over the whole-word write.
- R8: During a cycle with writes, both the read ports and `word_rdata` still return the pre-write values. There is no bypass.
- R9: With `rst` high at a rising edge, every field becomes zero, whatever writes are requested in that cycle.
- R10: With no write enables active, the stored word does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_idx | input | 8x3 | Field index for each read port |
| rd_data | output | 8x4 | Field value for each read port |
| wr_en | input | 8 | Enable for each field write port |
| wr_idx | input | 8x3 | Target field for each write port |
| wr_data | input | 8x4 | Data for each field write port |
| word_we | input | 1 | Whole-word write enable |
| word_wdata | input | 32 | Whole-word write data |
| word_rdata | output | 32 | All fields packed, field 0 in the top nibble |

## Verification
The bench goes after collisions, where two or more field ports hit one field in the same cycle. A design with a reversed priority loop would leave the lower port's nibble in the word. It also combines a whole-word load with a field write. A design that applied the word write last would lose the field port's value, and one with the nibble order reversed would put fields in mirrored positions. Each write cycle is also sampled before its edge: a design with a bypass would show the new value too early. Reset is asserted together with a word write, which catches a design that lets the write win over reset.

// File: rtl/cond_field_file.sv
module cond_field_file #(
  parameter int NF = 8,
  parameter int FW = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NF-1:0][$clog2(NF)-1:0] rd_idx,
  output logic [NF-1:0][FW-1:0]         rd_data,
  input  logic [NF-1:0]                 wr_en,
  input  logic [NF-1:0][$clog2(NF)-1:0] wr_idx,
  input  logic [NF-1:0][FW-1:0]         wr_data,
  input  logic                          word_we,
  input  logic [NF*FW-1:0]              word_wdata,
  output logic [NF*FW-1:0]              word_rdata
);
  localparam int IW = $clog2(NF);
  localparam int WW = NF * FW;

  logic [NF-1:0][FW-1:0] fld_q, fld_d;

  always_comb begin
    fld_d = fld_q;
    for (int f = 0; f < NF; f++) begin
      if (word_we) fld_d[f] = word_wdata[WW-1-f*FW -: FW];
      for (int p = 0; p < NF; p++)
        if (wr_en[p] && wr_idx[p] == IW'(f)) fld_d[f] = wr_data[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) fld_q <= '0;
    else     fld_q <= fld_d;
  end

  for (genvar p = 0; p < NF; p++) begin : g_rd
    assign rd_data[p] = fld_q[rd_idx[p]];
  end

  for (genvar f = 0; f < NF; f++) begin : g_word
    assign word_rdata[WW-1-f*FW -: FW] = fld_q[f];
  end
endmodule

// File: rtl/cond_field_file_chk.sv
module cond_field_file_chk #(
  parameter int NF = 8,
  parameter int FW = 4
) (
  input logic                          clk,
  input logic                          rst,
  input logic [NF-1:0][$clog2(NF)-1:0] rd_idx,
  input logic [NF-1:0][FW-1:0]         rd_data,
  input logic [NF-1:0]                 wr_en,
  input logic [NF-1:0][$clog2(NF)-1:0] wr_idx,
  input logic [NF-1:0][FW-1:0]         wr_data,
  input logic                          word_we,
  input logic [NF*FW-1:0]              word_wdata,
  input logic [NF*FW-1:0]              word_rdata
);
  localparam int IW = $clog2(NF);
  localparam int WW = NF * FW;

  function automatic logic [FW-1:0] nib(input logic [WW-1:0] w, input logic [IW-1:0] i);
    logic [WW-1:0] s;
    s = w >> (WW - FW - int'(i) * FW);
    return s[FW-1:0];
  endfunction

  AST_RESET_CLEAR: assert property (@(posedge clk) $past(rst) |-> word_rdata == '0); // R9

  AST_WORD_LOAD: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(word_we) && $past(wr_en) == '0 |-> word_rdata == $past(word_wdata)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(word_we) && $past(wr_en) == '0 |-> $stable(word_rdata)); // R10

  AST_TOP_PORT_WINS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(wr_en[NF-1]) |-> nib(word_rdata, $past(wr_idx[NF-1])) == $past(wr_data[NF-1])); // R6

  for (genvar p = 0; p < NF; p++) begin : g_rdchk
    AST_READ_MATCH: assert property (@(posedge clk) disable iff (rst)
      rd_data[p] == nib(word_rdata, rd_idx[p])); // R2
  end
endmodule

bind cond_field_file cond_field_file_chk #(.NF(NF), .FW(FW)) u_chk (
  .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_data(rd_data), .wr_en(wr_en),
  .wr_idx(wr_idx), .wr_data(wr_data), .word_we(word_we),
  .word_wdata(word_wdata), .word_rdata(word_rdata)
);

// File: tb/sim_cond_field_file.sv
module sim_cond_field_file;
  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [7:0][2:0]      rd_idx = '0;
  logic [7:0][3:0]      rd_data;
  logic [7:0]           wr_en = '0;
  logic [7:0][2:0]      wr_idx = '0;
  logic [7:0][3:0]      wr_data = '0;
  logic                 word_we = 1'b0;
  logic [31:0]          word_wdata = '0;
  logic [31:0]          word_rdata;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cond_field_file u0 (
    .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_data(rd_data), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .word_we(word_we),
    .word_wdata(word_wdata), .word_rdata(word_rdata)
  );

  typedef struct packed {
    logic [7:0]      en;
    logic [7:0][3:0] idx;
    logic [7:0][3:0] dat;
    logic            wwe;
    logic [31:0]     wdat;
    logic [31:0]     exp;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{8'h00, 32'h00000000, 32'h00000000, 1'b1, 32'h12345678, 32'h12345678}, // R4 R1
    '{8'h04, 32'h00000700, 32'h00000A00, 1'b0, 32'h0,        32'h1234567A}, // R5
    '{8'h22, 32'h00000000, 32'h00900030, 1'b0, 32'h0,        32'h9234567A}, // R6
    '{8'h01, 32'h00000003, 32'h00000000, 1'b1, 32'hFFFFFFFF, 32'hFFF0FFFF}, // R7
    '{8'h00, 32'h00000000, 32'h00000000, 1'b0, 32'h0,        32'hFFF0FFFF}, // R10
    '{8'hFF, 32'h76543210, 32'h76543210, 1'b0, 32'h0,        32'h01234567}, // R5 R1
    '{8'h51, 32'h02020002, 32'h0C050001, 1'b0, 32'h0,        32'h01C34567}  // R6
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    logic [31:0] prev;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R9 reset clear", word_rdata, 32'h0);
    prev = 32'h0;
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      wr_en = TBL[v].en;
      for (int p = 0; p < 8; p++) begin
        wr_idx[p]  = TBL[v].idx[p][2:0];
        wr_data[p] = TBL[v].dat[p];
      end
      word_we = TBL[v].wwe;
      word_wdata = TBL[v].wdat;
      #1 check("R8 no bypass", word_rdata, prev);
      @(posedge clk);
      #1 check($sformatf("R3 vector %0d", v), word_rdata, TBL[v].exp);
      prev = TBL[v].exp;
    end
    @(negedge clk);
    wr_en = '0;
    word_we = 1'b0;
    for (int p = 0; p < 8; p++) rd_idx[p] = 3'(7 - p);
    #1;
    for (int p = 0; p < 8; p++) begin
      logic [3:0] e;
      e = (7 - p == 2) ? 4'hC : 4'(7 - p);
      check($sformatf("R2 read port %0d", p), {28'h0, rd_data[p]}, {28'h0, e});
    end
    @(negedge clk);
    rst = 1'b1;
    word_we = 1'b1;
    word_wdata = 32'hDEADBEEF;
    wr_en = 8'h01;
    wr_idx[0] = 3'd5;
    wr_data[0] = 4'h9;
    @(posedge clk);
    #1 check("R9 reset beats writes", word_rdata, 32'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule